// File: doc/BRIEF.md
# SMBus Host Command Sequencer

This block sits between a host that wants to run one SMBus transaction and a byte-level I2C master engine. The host presents a single command (its kind, a 7-bit target address, a command code and write data). The sequencer turns that command into the ordered chain of byte operations the protocol needs: start with address and direction, send, receive, master NACK and stop. It hands these to the engine one at a time.

Every operation stays on the engine interface until the engine reports completion. For starts, the engine also reports whether the target acknowledged. Read data is gathered into a result word, or for block reads into a 32-entry byte buffer. The outcome is reported with a one-cycle done pulse, an error flag and a result word. The same buffer supplies the data bytes of block writes. The host loads it and reads it back through its own port.

Top module: `smbus_cmd_seq`

## Requirements
- R1: `cmd_ready_o` is high only while the sequencer is idle. A command is taken when `cmd_valid_i` and `cmd_ready_o` are both high at a clock edge, and `cmd_ready_o` is low from the next cycle until the command has finished. Kind codes on `cmd_kind_i`: 0 quick, 1 send byte, 2 receive byte, 3 write byte, 4 read byte, 5 write word, 6 read word, 7 block write, 8 block read.
- R2: Each operation is held unchanged on `op_valid_o`/`op_kind_o`/`op_wdata_o` until `op_done_i`. The following operation appears in the cycle after that completion. Kind codes on `op_kind_o`: 0 start, 1 send, 2 receive, 3 NACK, 4 stop. `op_addr_o` carries the command's target address, and `op_rw_o` is 1 for a read start.
- R3: A quick command is one start whose direction is `cmd_rw_i`, then a stop. It completes without error.
- R4: If the first start of any command is not acknowledged (`op_ack_i` = 0), no further operation is issued and the command completes with `err_o` = 1.
- R5: Send byte is start(write), send `cmd_code_i`, stop. Receive byte is start(read), receive, NACK, stop, and it returns the byte in `result_o[7:0]`.
- R6: Write byte and write word are start(write), send code, send `cmd_wdata_i[7:0]`, then for word also `cmd_wdata_i[15:8]`, then stop.
- R7: Read byte and read word are start(write), send code, start(read), receive one or two bytes, NACK, stop. In a word the first byte received is the low half of `result_o`.
- R8: If the repeated read start is not acknowledged, a stop follows and the command completes with `err_o` = 1.
- R9: Block write sends the code, then a length equal to `cmd_len_i` clamped to 32, then that many bytes from buffer entries 0 upward, then stop.
- R10: Block read receives a count byte, and any count above 32 becomes 0. It then receives that many bytes into buffer entries 0 upward, then NACK and stop, and reports the count in `result_o`.
- R11: `done_o` is a single-cycle pulse in the cycle after the stop completes, or after the failed first start. `err_o` and `result_o` hold their values until the next command is accepted.
- R12: A host buffer write (`buf_we_i`) is ignored while a command is in progress and takes effect while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command request |
| cmd_ready_o | output | 1 | Sequencer idle, command can be taken |
| cmd_kind_i | input | 4 | Command kind code |
| cmd_addr_i | input | 7 | Target address |
| cmd_rw_i | input | 1 | Direction for quick command (1 = read) |
| cmd_code_i | input | 8 | Command code or send-byte data |
| cmd_wdata_i | input | 16 | Write byte/word data, low byte first |
| cmd_len_i | input | 8 | Block write length |
| buf_we_i | input | 1 | Host buffer write enable |
| buf_waddr_i | input | 5 | Host buffer write index |
| buf_wdata_i | input | 8 | Host buffer write data |
| buf_raddr_i | input | 5 | Host buffer read index |
| buf_rdata_o | output | 8 | Host buffer read data (combinational) |
| op_valid_o | output | 1 | Byte operation pending for the engine |
| op_kind_o | output | 3 | Byte operation kind |
| op_addr_o | output | 7 | Target address for starts |
| op_rw_o | output | 1 | Start direction (1 = read) |
| op_wdata_o | output | 8 | Byte to send |
| op_done_i | input | 1 | Engine completed the pending operation |
| op_ack_i | input | 1 | Target acknowledged (valid with op_done_i on starts) |
| op_rdata_i | input | 8 | Received byte (valid with op_done_i on receives) |
| done_o | output | 1 | Command complete pulse |
| err_o | output | 1 | Last command failed |
| result_o | output | 16 | Read byte/word or block count |

## Verification
An accepted command shows its first start on the engine interface in the cycle after acceptance. Each later operation appears in the cycle after the engine's completion of the previous one, and `done_o` rises in the cycle after the final stop or failed start completes. The bench's engine model answers every operation one cycle after it is presented. At the falling edge following each completion, it checks either that the next operation is already pending or, for the last operation of a command, that `done_o` is high. A separate monitor compares the reported error and result on that same pulse. Buffer contents are read back while idle through the combinational host port, one time step after the index is set.

// File: rtl/smbus_seq_pkg.sv
package smbus_seq_pkg;

  typedef enum logic [3:0] {
    CMD_QUICK       = 4'd0,
    CMD_SEND_BYTE   = 4'd1,
    CMD_RECV_BYTE   = 4'd2,
    CMD_WRITE_BYTE  = 4'd3,
    CMD_READ_BYTE   = 4'd4,
    CMD_WRITE_WORD  = 4'd5,
    CMD_READ_WORD   = 4'd6,
    CMD_WRITE_BLOCK = 4'd7,
    CMD_READ_BLOCK  = 4'd8
  } cmd_kind_e;

  typedef enum logic [2:0] {
    OP_START = 3'd0,
    OP_SEND  = 3'd1,
    OP_RECV  = 3'd2,
    OP_NACK  = 3'd3,
    OP_STOP  = 3'd4
  } op_kind_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CODE,
    ST_BLEN,
    ST_WDAT,
    ST_RADDR,
    ST_RCNT,
    ST_RDAT,
    ST_NACK,
    ST_STOP,
    ST_DONE
  } seq_state_e;

endpackage

// File: rtl/smbus_blk_buf.sv
module smbus_blk_buf #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          host_we_i,
  input  logic [AW-1:0] host_waddr_i,
  input  logic [7:0]    host_wdata_i,
  input  logic [AW-1:0] host_raddr_i,
  output logic [7:0]    host_rdata_o,
  input  logic          seq_we_i,
  input  logic [AW-1:0] seq_addr_i,
  input  logic [7:0]    seq_wdata_i,
  output logic [7:0]    seq_rdata_o
);

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (seq_we_i) begin
      mem_q[seq_addr_i] <= seq_wdata_i;
    end else if (host_we_i) begin
      mem_q[host_waddr_i] <= host_wdata_i;
    end
  end

  assign host_rdata_o = mem_q[host_raddr_i];
  assign seq_rdata_o  = mem_q[seq_addr_i];

endmodule

// File: rtl/smbus_seq_fsm.sv
module smbus_seq_fsm
  import smbus_seq_pkg::*;
#(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned ADDR_W = 7,
  localparam int unsigned LEN_W = $clog2(DEPTH + 1),
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [3:0]        cmd_kind_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic              cmd_rw_i,
  input  logic [7:0]        cmd_code_i,
  input  logic [15:0]       cmd_wdata_i,
  input  logic [7:0]        cmd_len_i,
  output logic              op_valid_o,
  output logic [2:0]        op_kind_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic              op_rw_o,
  output logic [7:0]        op_wdata_o,
  input  logic              op_done_i,
  input  logic              op_ack_i,
  input  logic [7:0]        op_rdata_i,
  output logic              buf_we_o,
  output logic [AW-1:0]     buf_addr_o,
  output logic [7:0]        buf_wdata_o,
  input  logic [7:0]        buf_rdata_i,
  output logic              done_o,
  output logic              err_o,
  output logic [15:0]       result_o
);

  seq_state_e        state_q;
  cmd_kind_e         kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rw_q;
  logic [7:0]        code_q;
  logic [15:0]       wdata_q;
  logic [LEN_W-1:0]  len_q, idx_q, total;
  logic [15:0]       res_q;
  logic              err_q;
  logic              last;
  logic [LEN_W-1:0]  cnt_cap, len_cap;
  op_kind_e          op_kind;

  // byte count of the data phase
  always_comb begin
    case (kind_q)
      CMD_WRITE_BYTE, CMD_READ_BYTE, CMD_RECV_BYTE: total = LEN_W'(1);
      CMD_WRITE_WORD, CMD_READ_WORD:                total = LEN_W'(2);
      default:                                      total = len_q;
    endcase
  end

  assign last    = (idx_q + LEN_W'(1)) == total;
  assign cnt_cap = (op_rdata_i > 8'(DEPTH)) ? '0 : LEN_W'(op_rdata_i);
  assign len_cap = (cmd_len_i > 8'(DEPTH)) ? LEN_W'(DEPTH) : LEN_W'(cmd_len_i);

  always_comb begin
    op_kind    = OP_STOP;
    op_rw_o    = 1'b0;
    op_wdata_o = '0;
    case (state_q)
      ST_ADDR: begin
        op_kind = OP_START;
        op_rw_o = (kind_q == CMD_QUICK) ? rw_q : (kind_q == CMD_RECV_BYTE);
      end
      ST_CODE: begin
        op_kind    = OP_SEND;
        op_wdata_o = code_q;
      end
      ST_BLEN: begin
        op_kind    = OP_SEND;
        op_wdata_o = 8'(len_q);
      end
      ST_WDAT: begin
        op_kind = OP_SEND;
        if (kind_q == CMD_WRITE_BLOCK) op_wdata_o = buf_rdata_i;
        else op_wdata_o = idx_q[0] ? wdata_q[15:8] : wdata_q[7:0];
      end
      ST_RADDR: begin
        op_kind = OP_START;
        op_rw_o = 1'b1;
      end
      ST_RCNT, ST_RDAT: op_kind = OP_RECV;
      ST_NACK:          op_kind = OP_NACK;
      default:          op_kind = OP_STOP;
    endcase
  end

  assign op_valid_o  = !(state_q inside {ST_IDLE, ST_DONE});
  assign op_kind_o   = op_kind;
  assign op_addr_o   = addr_q;
  assign cmd_ready_o = (state_q == ST_IDLE);
  assign done_o      = (state_q == ST_DONE);
  assign err_o       = err_q;
  assign result_o    = res_q;

  assign buf_we_o    = (state_q == ST_RDAT) && op_done_i && (kind_q == CMD_READ_BLOCK);
  assign buf_addr_o  = AW'(idx_q);
  assign buf_wdata_o = op_rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      kind_q  <= CMD_QUICK;
      addr_q  <= '0;
      rw_q    <= 1'b0;
      code_q  <= '0;
      wdata_q <= '0;
      len_q   <= '0;
      idx_q   <= '0;
      res_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (cmd_valid_i) begin
          kind_q  <= cmd_kind_e'(cmd_kind_i);
          addr_q  <= cmd_addr_i;
          rw_q    <= cmd_rw_i;
          code_q  <= cmd_code_i;
          wdata_q <= cmd_wdata_i;
          len_q   <= len_cap;
          idx_q   <= '0;
          res_q   <= '0;
          err_q   <= 1'b0;
          state_q <= ST_ADDR;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: if (op_done_i) begin
          case (state_q)
            ST_ADDR: begin
              if (!op_ack_i) begin
                err_q   <= 1'b1;
                state_q <= ST_DONE;
              end else begin
                case (kind_q)
                  CMD_QUICK:     state_q <= ST_STOP;
                  CMD_RECV_BYTE: state_q <= ST_RDAT;
                  default:       state_q <= ST_CODE;
                endcase
              end
            end
            ST_CODE: begin
              case (kind_q)
                CMD_WRITE_BYTE, CMD_WRITE_WORD:              state_q <= ST_WDAT;
                CMD_WRITE_BLOCK:                             state_q <= ST_BLEN;
                CMD_READ_BYTE, CMD_READ_WORD, CMD_READ_BLOCK: state_q <= ST_RADDR;
                default:                                     state_q <= ST_STOP;
              endcase
            end
            ST_BLEN: state_q <= (len_q == '0) ? ST_STOP : ST_WDAT;
            ST_WDAT: begin
              if (last) state_q <= ST_STOP;
              else idx_q <= idx_q + LEN_W'(1);
            end
            ST_RADDR: begin
              if (!op_ack_i) begin
                err_q   <= 1'b1;
                state_q <= ST_STOP;
              end else begin
                state_q <= (kind_q == CMD_READ_BLOCK) ? ST_RCNT : ST_RDAT;
              end
            end
            ST_RCNT: begin
              res_q   <= 16'(cnt_cap);
              len_q   <= cnt_cap;
              state_q <= (cnt_cap == '0) ? ST_NACK : ST_RDAT;
            end
            ST_RDAT: begin
              if (kind_q != CMD_READ_BLOCK) begin
                if (idx_q[0]) res_q[15:8] <= op_rdata_i;
                else res_q[7:0] <= op_rdata_i;
              end
              if (last) state_q <= ST_NACK;
              else idx_q <= idx_q + LEN_W'(1);
            end
            ST_NACK: state_q <= ST_STOP;
            default: state_q <= ST_DONE;
          endcase
        end
      endcase
    end
  end

  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_ready_o |=> !cmd_ready_o); // R1

  AST_OP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o && !op_done_i |=> op_valid_o && $stable(op_kind_o) && $stable(op_wdata_o)); // R2

  AST_ADDR_NACK_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_ADDR && op_done_i && !op_ack_i |=> done_o && err_o); // R4

  AST_BLEN_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o && state_q == ST_BLEN |-> op_wdata_o <= 8'(DEPTH)); // R9

  AST_BLK_COUNT_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && kind_q == CMD_READ_BLOCK |-> result_o <= 16'(DEPTH)); // R10

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11

  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o && !cmd_valid_i |=> $stable(result_o) && $stable(err_o)); // R11

endmodule

// File: rtl/smbus_cmd_seq.sv
module smbus_cmd_seq #(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned ADDR_W = 7,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [3:0]        cmd_kind_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic              cmd_rw_i,
  input  logic [7:0]        cmd_code_i,
  input  logic [15:0]       cmd_wdata_i,
  input  logic [7:0]        cmd_len_i,
  input  logic              buf_we_i,
  input  logic [AW-1:0]     buf_waddr_i,
  input  logic [7:0]        buf_wdata_i,
  input  logic [AW-1:0]     buf_raddr_i,
  output logic [7:0]        buf_rdata_o,
  output logic              op_valid_o,
  output logic [2:0]        op_kind_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic              op_rw_o,
  output logic [7:0]        op_wdata_o,
  input  logic              op_done_i,
  input  logic              op_ack_i,
  input  logic [7:0]        op_rdata_i,
  output logic              done_o,
  output logic              err_o,
  output logic [15:0]       result_o
);

  logic          seq_we;
  logic [AW-1:0] seq_addr;
  logic [7:0]    seq_wdata, seq_rdata;
  logic          host_we;

  // host writes only land while idle
  assign host_we = buf_we_i && cmd_ready_o;

  smbus_blk_buf #(.DEPTH(DEPTH)) i_buf (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .host_we_i    (host_we),
    .host_waddr_i (buf_waddr_i),
    .host_wdata_i (buf_wdata_i),
    .host_raddr_i (buf_raddr_i),
    .host_rdata_o (buf_rdata_o),
    .seq_we_i     (seq_we),
    .seq_addr_i   (seq_addr),
    .seq_wdata_i  (seq_wdata),
    .seq_rdata_o  (seq_rdata)
  );

  smbus_seq_fsm #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_ready_o (cmd_ready_o),
    .cmd_kind_i  (cmd_kind_i),
    .cmd_addr_i  (cmd_addr_i),
    .cmd_rw_i    (cmd_rw_i),
    .cmd_code_i  (cmd_code_i),
    .cmd_wdata_i (cmd_wdata_i),
    .cmd_len_i   (cmd_len_i),
    .op_valid_o  (op_valid_o),
    .op_kind_o   (op_kind_o),
    .op_addr_o   (op_addr_o),
    .op_rw_o     (op_rw_o),
    .op_wdata_o  (op_wdata_o),
    .op_done_i   (op_done_i),
    .op_ack_i    (op_ack_i),
    .op_rdata_i  (op_rdata_i),
    .buf_we_o    (seq_we),
    .buf_addr_o  (seq_addr),
    .buf_wdata_o (seq_wdata),
    .buf_rdata_i (seq_rdata),
    .done_o      (done_o),
    .err_o       (err_o),
    .result_o    (result_o)
  );

  AST_HOST_WR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we_i && !cmd_ready_o |=> $stable(buf_rdata_o) || !$stable(buf_raddr_i) || $past(seq_we)); // R12

endmodule

// File: tb/test_smbus_cmd_seq.sv
module test_smbus_cmd_seq;
  import smbus_seq_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 100000;
  localparam logic [6:0] TGT = 7'h2A;

  typedef struct {
    logic [2:0]  kind;
    logic        rw;
    logic [7:0]  data;
    logic        ack;
    logic [7:0]  rdata;
    logic        tail;
    logic [31:0] req;
  } exp_op_t;

  typedef struct {
    logic        err;
    logic [15:0] val;
    logic [31:0] req;
  } exp_res_t;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cmd_valid_i = 1'b0;
  logic cmd_ready_o;
  logic [3:0] cmd_kind_i = '0;
  logic [6:0] cmd_addr_i = '0;
  logic cmd_rw_i = 1'b0;
  logic [7:0] cmd_code_i = '0;
  logic [15:0] cmd_wdata_i = '0;
  logic [7:0] cmd_len_i = '0;
  logic buf_we_i = 1'b0;
  logic [4:0] buf_waddr_i = '0;
  logic [7:0] buf_wdata_i = '0;
  logic [4:0] buf_raddr_i = '0;
  logic [7:0] buf_rdata_o;
  logic op_valid_o;
  logic [2:0] op_kind_o;
  logic [6:0] op_addr_o;
  logic op_rw_o;
  logic [7:0] op_wdata_o;
  logic op_done_i = 1'b0;
  logic op_ack_i = 1'b0;
  logic [7:0] op_rdata_i = '0;
  logic done_o;
  logic err_o;
  logic [15:0] result_o;

  int checks = 0;
  int errors = 0;
  exp_op_t  exp_q[$];
  exp_res_t res_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  smbus_cmd_seq i_smbus_cmd_seq (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_ready_o, .cmd_kind_i, .cmd_addr_i,
    .cmd_rw_i, .cmd_code_i, .cmd_wdata_i, .cmd_len_i, .buf_we_i, .buf_waddr_i,
    .buf_wdata_i, .buf_raddr_i, .buf_rdata_o, .op_valid_o, .op_kind_o,
    .op_addr_o, .op_rw_o, .op_wdata_o, .op_done_i, .op_ack_i, .op_rdata_i,
    .done_o, .err_o, .result_o
  );

  task automatic chk(input logic [31:0] req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] bval(input int i);
    return 8'(i * 7 + 3);
  endfunction

  task automatic eop(input op_kind_e k, input logic rw, input logic [7:0] d,
                     input logic ack, input logic [7:0] rd, input logic tail,
                     input logic [31:0] req);
    exp_op_t e;
    e.kind = k; e.rw = rw; e.data = d; e.ack = ack; e.rdata = rd;
    e.tail = tail; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic eres(input logic err, input logic [15:0] val, input logic [31:0] req);
    exp_res_t r;
    r.err = err; r.val = val; r.req = req;
    res_q.push_back(r);
  endtask

  task automatic send_cmd(input cmd_kind_e k, input logic rw, input logic [7:0] code,
                          input logic [15:0] wd, input logic [7:0] len);
    @(negedge clk_i);
    while (!cmd_ready_o) @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_kind_i = k; cmd_addr_i = TGT; cmd_rw_i = rw;
    cmd_code_i = code; cmd_wdata_i = wd; cmd_len_i = len;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    chk("R1", "ready while busy", int'(cmd_ready_o), 0);
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0 || res_q.size() != 0) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic rd_buf(input int idx, input logic [7:0] exp, input logic [31:0] req);
    @(negedge clk_i);
    buf_raddr_i = 5'(idx);
    #1;
    chk(req, "buffer readback", int'(buf_rdata_o), int'(exp));
  endtask

  // engine model: checks each operation against the scoreboard and answers it
  initial begin
    exp_op_t e;
    forever begin
      @(negedge clk_i);
      if (op_valid_o && rst_ni) begin
        if (exp_q.size() == 0) begin
          chk("R2", "unexpected operation kind", int'(op_kind_o), 7);
          e.ack = 1'b1; e.rdata = '0; e.tail = 1'b0; e.req = "R2";
          e.kind = op_kind_o;
        end else begin
          e = exp_q.pop_front();
          chk(e.req, "op kind", int'(op_kind_o), int'(e.kind));
          if (e.kind == OP_START) begin
            chk(e.req, "start direction", int'(op_rw_o), int'(e.rw));
            chk("R2", "start address", int'(op_addr_o), int'(TGT));
          end
          if (e.kind == OP_SEND) chk(e.req, "sent byte", int'(op_wdata_o), int'(e.data));
        end
        @(negedge clk_i);
        op_done_i = 1'b1; op_ack_i = e.ack; op_rdata_i = e.rdata;
        @(negedge clk_i);
        op_done_i = 1'b0; op_ack_i = 1'b0;
        if (e.tail) chk("R11", "done one cycle after last op", int'(done_o), 1);
        else chk("R2", "next op one cycle after completion", int'(op_valid_o), 1);
      end
    end
  end

  // result monitor
  initial begin
    exp_res_t r;
    forever begin
      @(negedge clk_i);
      if (done_o && rst_ni) begin
        if (res_q.size() == 0) begin
          chk("R11", "unexpected done", 1, 0);
        end else begin
          r = res_q.pop_front();
          chk(r.req, "error flag", int'(err_o), int'(r.err));
          chk(r.req, "result", int'(result_o), int'(r.val));
        end
      end
    end
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL R2 watchdog expired: actual hung expected finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1", "ready in reset", int'(cmd_ready_o), 1);
    chk("R2", "no op in reset", int'(op_valid_o), 0);
    chk("R11", "no done in reset", int'(done_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "ready after reset", int'(cmd_ready_o), 1);

    // R3 quick write and quick read
    eop(OP_START, 1'b0, 8'h00, 1'b1, 8'h00, 1'b0, "R3");
    eop(OP_STOP,  1'b0, 8'h00, 1'b1, 8'h00, 1'b1, "R3");
    eres(1'b0, 16'h0000, "R3");
    send_cmd(CMD_QUICK, 1'b0, 8'h00, 16'h0, 8'h0); wait_idle();
    eop(OP_START, 1'b1, 8'h00, 1'b1, 8'h00, 1'b0, "R3");
    eop(OP_STOP,  1'b0, 8'h00, 1'b1, 8'h00, 1'b1, "R3");
    eres(1'b0, 16'h0000, "R3");
    send_cmd(CMD_QUICK, 1'b1, 8'h00, 16'h0, 8'h0); wait_idle();

    // R4 first start not acknowledged
    eop(OP_START, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, "R4");
    eres(1'b1, 16'h0000, "R4");
    send_cmd(CMD_QUICK, 1'b0, 8'h00, 16'h0, 8'h0); wait_idle();
    eop(OP_START, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, "R4");
    eres(1'b1, 16'h0000, "R4");
    send_cmd(CMD_READ_WORD, 1'b0, 8'h40, 16'h0, 8'h0); wait_idle();

    // R5 send byte, receive byte
    eop(OP_START, 1'b0, 8'h00, 1'b1, 8'h00, 1'b0, "R5");
    eop(OP_SEND,  1'b0, 8'h5C, 1'b1, 8'h00, 1'b0, "R5");
    eop(OP_STOP,  1'b0, 8'h00, 1'b1, 8'h00, 1'b1, "R5");
    eres(1'b0, 16'h0000, "R5");
    send_cmd(CMD_SEND_BYTE, 1'b0, 8'h5C, 16'h0, 8'h0); wait_idle();
    eop(OP_START, 1'b1, 8'h00, 1'b1, 8'h00, 1'b0, "R5");
    eop(OP_RECV,  1'b0, 8'h00, 1'b1, 8'h9E, 1'b0, "R5");
    eop(OP_NACK,  1'b0, 8'h00, 1'b1, 8'h00, 1'b0, "R5");
    eop(OP_STOP,  1'b0, 8'h00, 1'b1, 8'h00, 1'b1, "R5");
    eres(1'b0, 16'h009E, "R5");
    send_cmd(CMD_RECV_BYTE, 1'b0, 8'h00, 16'h0, 8'h0); wait_idle();

    // R6 write byte, write word (low byte first)
    eop(OP_START, 1'b0, 8'h00, 1'b1, 8'h00, 1'b0, "R6");
    eop(OP_SEND,  1'b0, 8'h11, 1'b1, 8'h00, 1'b0, "R6");
    eop(OP_SEND,  1'b0, 8'h77, 1'b1, 8'h00, 1'b0, "R6");
    eop(OP_STOP,  1'b0, 8'h00, 1'b1, 8'h00, 1'b1, "R6");
    eres(1'b0, 16'h0000, "R6");
    send_cmd(CMD_WRITE_BYTE, 1'b0, 8'h11, 16'hAA77, 8'h0); wait_idle();
    eop(OP_START, 1'b0, 8'h00, 1'b1, 8'h00, 1'b0, "R6");
    eop(OP_SEND,  1'b0, 8'h22, 1'b1, 8'h00, 1'b0, "R6");
    eop(OP_SEND,  1'b0, 8'hEF, 1'b1, 8'h00, 1'b0, "R6");
    eop(OP_SEND,  1'b0, 8'hBE, 1'b1, 8'h00, 1'b0, "R6");
    eop(OP_STOP,  1'b0, 8'h00, 1'b1, 8'h00, 1'b1, "R6");
    eres(1'b0, 16'h0000, "R6");
    send_cmd(CMD_WRITE_WORD, 1'b0, 8'h22, 16'hBEEF, 8'h0); wait_idle();

    // R7 read byte, read word
    eop(OP_START, 1'b0, 8'h00, 1'b1, 8'h00, 1'b0, "R7");
    eop(OP_SEND,  1'b0, 8'h33, 1'b1, 8'h00, 1'b0, "R7");
    eop(OP_START, 1'b1, 8'h00, 1'b1, 8'h00, 1'b0, "R7");
    eop(OP_RECV,  1'b0, 8'h00, 1'b1, 8'h3C, 1'b0, "R7");
    eop(OP_NACK,  1'b0, 8'h00, 1'b1, 8'h00, 1'b0, "R7");
    eop(OP_STOP,  1'b0, 8'h00, 1'b1, 8'h00, 1'b1, "R7");
    eres(1'b0, 16'h003C, "R7");
    send_cmd(CMD_READ_BYTE, 1'b0, 8'h33, 16'h0, 8'h0); wait_idle();
    eop(OP_START, 1'b0, 8'h00, 1'b1, 8'h00, 1'b0, "R7");
    eop(OP_SEND,  1'b0, 8'h44, 1'b1, 8'h00, 1'b0, "R7");
    eop(OP_START, 1'b1, 8'h00, 1'b1, 8'h00, 1'b0, "R7");
    eop(OP_RECV,  1'b0, 8'h00, 1'b1, 8'h34, 1'b0, "R7");
    eop(OP_RECV,  1'b0, 8'h00, 1'b1, 8'h12, 1'b0, "R7");
    eop(OP_NACK,  1'b0, 8'h00, 1'b1, 8'h00, 1'b0, "R7");
    eop(OP_STOP,  1'b0, 8'h00, 1'b1, 8'h00, 1'b1, "R7");
    eres(1'b0, 16'h1234, "R7");
    send_cmd(CMD_READ_WORD, 1'b0, 8'h44, 16'h0, 8'h0); wait_idle();
    repeat (3) @(negedge clk_i);
    chk("R11", "result held while idle", int'(result_o), 16'h1234);
    chk("R11", "error held while idle", int'(err_o), 0);

    // R8 repeated start not acknowledged
    eop(OP_START, 1'b0, 8'h00, 1'b1, 8'h00, 1'b0, "R8");
    eop(OP_SEND,  1'b0, 8'h55, 1'b1, 8'h00, 1'b0, "R8");
    eop(OP_START, 1'b1, 8'h00, 1'b0, 8'h00, 1'b0, "R8");
    eop(OP_STOP,  1'b0, 8'h00, 1'b1, 8'h00, 1'b1, "R8");
    eres(1'b1, 16'h0000, "R8");
    send_cmd(CMD_READ_BYTE, 1'b0, 8'h55, 16'h0, 8'h0); wait_idle();

    // load buffer while idle
    for (int i = 0; i < 32; i++) begin
      @(negedge clk_i);
      buf_we_i = 1'b1; buf_waddr_i = 5'(i); buf_wdata_i = bval(i);
    end
    @(negedge clk_i);
    buf_we_i = 1'b0;
    rd_buf(31, bval(31), "R12");

    // R9 block write, length 3, 40 (clamped) and 0
    eop(OP_START, 1'b0, 8'h00, 1'b1, 8'h00, 1'b0, "R9");
    eop(OP_SEND,  1'b0, 8'h66, 1'b1, 8'h00, 1'b0, "R9");
    eop(OP_SEND,  1'b0, 8'd3,  1'b1, 8'h00, 1'b0, "R9");
    for (int i = 0; i < 3; i++) eop(OP_SEND, 1'b0, bval(i), 1'b1, 8'h00, 1'b0, "R9");
    eop(OP_STOP,  1'b0, 8'h00, 1'b1, 8'h00, 1'b1, "R9");
    eres(1'b0, 16'h0000, "R9");
    send_cmd(CMD_WRITE_BLOCK, 1'b0, 8'h66, 16'h0, 8'd3); wait_idle();
    eop(OP_START, 1'b0, 8'h00, 1'b1, 8'h00, 1'b0, "R9");
    eop(OP_SEND,  1'b0, 8'h67, 1'b1, 8'h00, 1'b0, "R9");
    eop(OP_SEND,  1'b0, 8'd32, 1'b1, 8'h00, 1'b0, "R9");
    for (int i = 0; i < 32; i++) eop(OP_SEND, 1'b0, bval(i), 1'b1, 8'h00, 1'b0, "R9");
    eop(OP_STOP,  1'b0, 8'h00, 1'b1, 8'h00, 1'b1, "R9");
    eres(1'b0, 16'h0000, "R9");
    send_cmd(CMD_WRITE_BLOCK, 1'b0, 8'h67, 16'h0, 8'd40); wait_idle();
    eop(OP_START, 1'b0, 8'h00, 1'b1, 8'h00, 1'b0, "R9");
    eop(OP_SEND,  1'b0, 8'h68, 1'b1, 8'h00, 1'b0, "R9");
    eop(OP_SEND,  1'b0, 8'd0,  1'b1, 8'h00, 1'b0, "R9");
    eop(OP_STOP,  1'b0, 8'h00, 1'b1, 8'h00, 1'b1, "R9");
    eres(1'b0, 16'h0000, "R9");
    send_cmd(CMD_WRITE_BLOCK, 1'b0, 8'h68, 16'h0, 8'd0); wait_idle();

    // R10 block read, count 4 then count 50 (treated as 0)
    eop(OP_START, 1'b0, 8'h00, 1'b1, 8'h00, 1'b0, "R10");
    eop(OP_SEND,  1'b0, 8'h70, 1'b1, 8'h00, 1'b0, "R10");
    eop(OP_START, 1'b1, 8'h00, 1'b1, 8'h00, 1'b0, "R10");
    eop(OP_RECV,  1'b0, 8'h00, 1'b1, 8'd4,  1'b0, "R10");
    for (int i = 0; i < 4; i++) eop(OP_RECV, 1'b0, 8'h00, 1'b1, 8'(8'hA0 + i), 1'b0, "R10");
    eop(OP_NACK,  1'b0, 8'h00, 1'b1, 8'h00, 1'b0, "R10");
    eop(OP_STOP,  1'b0, 8'h00, 1'b1, 8'h00, 1'b1, "R10");
    eres(1'b0, 16'd4, "R10");
    send_cmd(CMD_READ_BLOCK, 1'b0, 8'h70, 16'h0, 8'h0); wait_idle();
    for (int i = 0; i < 4; i++) rd_buf(i, 8'(8'hA0 + i), "R10");
    rd_buf(4, bval(4), "R10");
    eop(OP_START, 1'b0, 8'h00, 1'b1, 8'h00, 1'b0, "R10");
    eop(OP_SEND,  1'b0, 8'h71, 1'b1, 8'h00, 1'b0, "R10");
    eop(OP_START, 1'b1, 8'h00, 1'b1, 8'h00, 1'b0, "R10");
    eop(OP_RECV,  1'b0, 8'h00, 1'b1, 8'd50, 1'b0, "R10");
    eop(OP_NACK,  1'b0, 8'h00, 1'b1, 8'h00, 1'b0, "R10");
    eop(OP_STOP,  1'b0, 8'h00, 1'b1, 8'h00, 1'b1, "R10");
    eres(1'b0, 16'd0, "R10");
    send_cmd(CMD_READ_BLOCK, 1'b0, 8'h71, 16'h0, 8'h0); wait_idle();

    // R12 host write during a command is dropped, while idle it lands
    eop(OP_START, 1'b0, 8'h00, 1'b1, 8'h00, 1'b0, "R12");
    eop(OP_STOP,  1'b0, 8'h00, 1'b1, 8'h00, 1'b1, "R12");
    eres(1'b0, 16'h0000, "R12");
    send_cmd(CMD_QUICK, 1'b0, 8'h00, 16'h0, 8'h0);
    buf_we_i = 1'b1; buf_waddr_i = 5'd5; buf_wdata_i = 8'hEE;
    @(negedge clk_i);
    buf_we_i = 1'b0;
    wait_idle();
    rd_buf(5, bval(5), "R12");
    @(negedge clk_i);
    buf_we_i = 1'b1; buf_waddr_i = 5'd6; buf_wdata_i = 8'h55;
    @(negedge clk_i);
    buf_we_i = 1'b0;
    rd_buf(6, 8'h55, "R12");

    repeat (4) @(negedge clk_i);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule